// File: doc/BRIEF.md
# Outbound MMIO Window and Segment Decoder

This block takes a CPU-side physical address and works out where it goes on the PCIe side. It holds one narrow window, which is at most 4 GB and translates addresses, and sixteen wide windows, which pass addresses through unchanged. For every address that hits a window it gives the PCIe address and an isolation group number. Each window is a naturally aligned power-of-two region and is divided into 256 equal segments. In the narrow window, a 256-entry table maps each segment to a group. In a wide window, either the segment index is the group number (segmented mode), or one configured group covers the whole window (unsegmented mode).

Configuration arrives one word per cycle on a simple write port. Lookups are presented with `req_valid` and answered one cycle later on a registered response. When windows overlap, a fixed priority decides which one answers. An address that no enabled window claims is flagged as a miss.

Top module: `mmio_route_decoder`

## Requirements
- R1: After reset every window is disabled and every segment table entry is 0. A lookup made then reports a miss.
- R2: A lookup presented with `req_valid` high at a rising edge is answered at that edge, with `rsp_valid` high and all response fields settled. In every other cycle `rsp_valid` is low and all response fields are 0.
- R3: An enabled wide window in unsegmented mode answers with its configured group, and `rsp_pci_addr` equals the CPU address.
- R4: An enabled wide window in segmented mode answers with group = ((address − window base) >> (log2 size − 8)), keeping the low 8 bits. `rsp_pci_addr` equals the CPU address.
- R5: The narrow window answers with group = table[segment], where segment is computed as in R4. `rsp_pci_addr` keeps the CPU address bits below the window size. Bits from the size up to bit 31 come from the programmed replacement value. Bits 32 and above are 0.
- R6: Among enabled wide windows that contain the address, the lowest-numbered one wins. Any wide hit beats the narrow window. `rsp_win` reports the winner: 0..15 for a wide window, 16 for the narrow window.
- R7: On a miss, `rsp_miss` is 1 and `rsp_win`, `rsp_grp` and `rsp_pci_addr` are all 0.
- R8: Base address bits below the window size are ignored, so every window is naturally aligned.
- R9: A size field is clamped on write. The narrow window accepts 16..32 and the wide windows accept 28..48. A value below the range becomes the minimum, and a value above it becomes the maximum.
- R10: The narrow window treats its top 64 KB like every other part of it. It forwards those addresses, and it translates them and looks up their group in the same way.
- R11: A configuration write with `cfg_we` high takes effect for lookups from the next cycle on. The target is chosen by `cfg_sel`:
  - 0 selects the narrow window. Its word holds the log2 size in bits [5:0], enable in bit [6], CPU base bits 47:16 in bits [47:16], and PCIe replacement bits 31:16 in bits [63:48].
  - 1 selects the wide window numbered `cfg_idx`. Indices 16 and above are ignored. Its word holds the log2 size in bits [5:0], enable in bit [6], segmented mode in bit [7], the whole-window group in bits [15:8], and base bits 47:16 in bits [47:16].
  - 2 selects table entry `cfg_idx`, which takes bits [7:0].
  - 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target kind |
| cfg_idx | input | 8 | Wide window number or table entry |
| cfg_wdata | input | 64 | Configuration word |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 48 | CPU physical address |
| rsp_valid | output | 1 | Response present |
| rsp_miss | output | 1 | No enabled window claimed the address |
| rsp_win | output | 5 | Winning window, 16 = narrow |
| rsp_grp | output | 8 | Isolation group number |
| rsp_pci_addr | output | 48 | Address on the PCIe side |

## Verification
Every lookup result is due exactly one rising edge after the request is presented. A configuration write changes the results of requests presented in the following cycle and after, never in the same cycle. The bench drives inputs just after a falling edge and predicts the response from its own model of the configuration as it stood before that edge. It then applies any write to the model and compares all response fields at the next falling edge. Because of this ordering, both the single-cycle latency and the write-takes-effect-next-cycle rule are checked on every clock.

// File: rtl/mmio_route_pkg.sv
package mmio_route_pkg;
    localparam int ADDR_W     = 48;
    localparam int SEG_W      = 8;
    localparam int GRP_W      = 8;
    localparam int N_WIDE     = 16;
    localparam int SZ_W       = 6;
    localparam int FIELD_LSB  = 16;
    localparam int REMAP_LSB  = 48;
    localparam int NARROW_TOP = 32;
    localparam int NARROW_MIN = 16;
    localparam int NARROW_MAX = 32;
    localparam int WIDE_MIN   = 28;
    localparam int WIDE_MAX   = ADDR_W;
    localparam int N_SEG      = 1 << SEG_W;
    localparam int WIN_W      = $clog2(N_WIDE + 1);
    localparam int CFG_W      = 64;

    typedef enum logic [1:0] {
        SEL_NARROW = 2'd0,
        SEL_WIDE   = 2'd1,
        SEL_TABLE  = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic                         en;
        logic [SZ_W-1:0]              sz;
        logic [ADDR_W-1:FIELD_LSB]    base;
        logic [NARROW_TOP-1:FIELD_LSB] remap;
    } narrow_cfg_t;

    typedef struct packed {
        logic                      en;
        logic                      seg;
        logic [SZ_W-1:0]           sz;
        logic [ADDR_W-1:FIELD_LSB] base;
        logic [GRP_W-1:0]          grp;
    } wide_cfg_t;

    typedef struct packed {
        logic              valid;
        logic              miss;
        logic [WIN_W-1:0]  win;
        logic [GRP_W-1:0]  grp;
        logic [ADDR_W-1:0] pci;
    } rsp_t;

    function automatic logic [SZ_W-1:0] clamp_sz(input logic [SZ_W-1:0] raw,
                                                 input int unsigned lo,
                                                 input int unsigned hi);
        if (32'(raw) < lo) return SZ_W'(lo);
        if (32'(raw) > hi) return SZ_W'(hi);
        return raw;
    endfunction
endpackage

// File: rtl/mmio_seg_table.sv
module mmio_seg_table
    import mmio_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  logic [GRP_W-1:0] wr_grp,
    input  logic [SEG_W-1:0] rd_idx,
    output logic [GRP_W-1:0] rd_grp
);
    logic [N_SEG-1:0][GRP_W-1:0] tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) tbl_d[wr_idx] = wr_grp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign rd_grp = tbl_q[rd_idx];
endmodule

// File: rtl/mmio_narrow_path.sv
module mmio_narrow_path
    import mmio_route_pkg::*;
(
    input  narrow_cfg_t       cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [SEG_W-1:0]  seg,
    output logic [ADDR_W-1:0] pci
);
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] base_full;
    logic [ADDR_W-1:0] remap_full;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        mask       = {ADDR_W{1'b1}} >> (SZ_W'(ADDR_W) - cfg.sz);
        base_full  = {cfg.base, {FIELD_LSB{1'b0}}};
        remap_full = ADDR_W'({cfg.remap, {FIELD_LSB{1'b0}}});
        offset     = addr & mask;
        hit        = cfg.en && (((addr ^ base_full) & ~mask) == '0);
        seg        = SEG_W'(offset >> (cfg.sz - SZ_W'(SEG_W)));
        pci        = (remap_full & ~mask) | offset;
    end
endmodule

// File: rtl/mmio_wide_bank.sv
module mmio_wide_bank
    import mmio_route_pkg::*;
(
    input  wide_cfg_t [N_WIDE-1:0]          cfg,
    input  logic [ADDR_W-1:0]               addr,
    output logic [N_WIDE-1:0]               hit,
    output logic [N_WIDE-1:0][GRP_W-1:0]    grp
);
    for (genvar w = 0; w < N_WIDE; w++) begin : g_win
        logic [ADDR_W-1:0] mask;
        logic [ADDR_W-1:0] base_full;
        logic [ADDR_W-1:0] offset;
        logic [SEG_W-1:0]  seg_num;

        always_comb begin
            mask      = {ADDR_W{1'b1}} >> (SZ_W'(ADDR_W) - cfg[w].sz);
            base_full = {cfg[w].base, {FIELD_LSB{1'b0}}};
            offset    = addr & mask;
            seg_num   = SEG_W'(offset >> (cfg[w].sz - SZ_W'(SEG_W)));
            hit[w]    = cfg[w].en && (((addr ^ base_full) & ~mask) == '0);
            grp[w]    = cfg[w].seg ? GRP_W'(seg_num) : cfg[w].grp;
        end
    end
endmodule

// File: rtl/mmio_win_pick.sv
module mmio_win_pick
    import mmio_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_WIDE-1:0] wide_hit,
    input  logic              narrow_hit,
    output logic [N_WIDE-1:0] grant,
    output logic [WIN_W-1:0]  win_idx,
    output logic              narrow_sel,
    output logic              any_hit
);
    always_comb begin
        grant      = '0;
        win_idx    = WIN_W'(N_WIDE);
        narrow_sel = narrow_hit;
        for (int i = N_WIDE - 1; i >= 0; i--) begin
            if (wide_hit[i]) begin
                grant      = '0;
                grant[i]   = 1'b1;
                win_idx    = WIN_W'(i);
                narrow_sel = 1'b0;
            end
        end
        any_hit = (|wide_hit) | narrow_hit;
        if (!any_hit) win_idx = '0;
    end

    // R6: at most one wide window is granted, and a granted window blocks the narrow path
    p_single_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && !(narrow_sel && (grant != '0)));

    // R6: a grant only goes to a window that reported a hit
    p_grant_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~wide_hit) == '0);
endmodule

// File: rtl/mmio_route_decoder.sv
module mmio_route_decoder
    import mmio_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [7:0]        cfg_idx,
    input  logic [63:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [47:0]       req_addr,
    output logic              rsp_valid,
    output logic              rsp_miss,
    output logic [4:0]        rsp_win,
    output logic [7:0]        rsp_grp,
    output logic [47:0]       rsp_pci_addr
);
    typedef struct packed {
        narrow_cfg_t              narrow;
        wide_cfg_t [N_WIDE-1:0]   wide;
        rsp_t                     rsp;
    } state_t;

    state_t st_d, st_q;

    logic                          tbl_we;
    logic [GRP_W-1:0]              tbl_grp;
    logic                          n_hit;
    logic [SEG_W-1:0]              n_seg;
    logic [ADDR_W-1:0]             n_pci;
    logic [N_WIDE-1:0]             w_hit;
    logic [N_WIDE-1:0][GRP_W-1:0]  w_grp;
    logic [N_WIDE-1:0]             grant;
    logic [WIN_W-1:0]              win_idx;
    logic                          narrow_sel;
    logic                          any_hit;

    mmio_seg_table u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_we),
        .wr_idx (cfg_idx),
        .wr_grp (cfg_wdata[GRP_W-1:0]),
        .rd_idx (n_seg),
        .rd_grp (tbl_grp)
    );

    mmio_narrow_path u_narrow (
        .cfg  (st_q.narrow),
        .addr (req_addr),
        .hit  (n_hit),
        .seg  (n_seg),
        .pci  (n_pci)
    );

    mmio_wide_bank u_wide (
        .cfg  (st_q.wide),
        .addr (req_addr),
        .hit  (w_hit),
        .grp  (w_grp)
    );

    mmio_win_pick u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .wide_hit   (w_hit),
        .narrow_hit (n_hit),
        .grant      (grant),
        .win_idx    (win_idx),
        .narrow_sel (narrow_sel),
        .any_hit    (any_hit)
    );

    always_comb begin
        st_d   = st_q;
        tbl_we = 1'b0;

        if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_NARROW: begin
                    st_d.narrow.en    = cfg_wdata[6];
                    st_d.narrow.sz    = clamp_sz(cfg_wdata[SZ_W-1:0], NARROW_MIN, NARROW_MAX);
                    st_d.narrow.base  = cfg_wdata[ADDR_W-1:FIELD_LSB];
                    st_d.narrow.remap = cfg_wdata[CFG_W-1:REMAP_LSB];
                end
                SEL_WIDE: begin
                    for (int i = 0; i < N_WIDE; i++) begin
                        if (cfg_idx == 8'(i)) begin
                            st_d.wide[i].en   = cfg_wdata[6];
                            st_d.wide[i].seg  = cfg_wdata[7];
                            st_d.wide[i].sz   = clamp_sz(cfg_wdata[SZ_W-1:0], WIDE_MIN, WIDE_MAX);
                            st_d.wide[i].grp  = cfg_wdata[8 +: GRP_W];
                            st_d.wide[i].base = cfg_wdata[ADDR_W-1:FIELD_LSB];
                        end
                    end
                end
                SEL_TABLE: tbl_we = 1'b1;
                default: ;
            endcase
        end

        st_d.rsp = '0;
        if (req_valid) begin
            st_d.rsp.valid = 1'b1;
            if (!any_hit) begin
                st_d.rsp.miss = 1'b1;
            end else if (narrow_sel) begin
                st_d.rsp.win = WIN_W'(N_WIDE);
                st_d.rsp.grp = tbl_grp;
                st_d.rsp.pci = n_pci;
            end else begin
                st_d.rsp.win = win_idx;
                st_d.rsp.pci = req_addr;
                for (int i = 0; i < N_WIDE; i++) begin
                    if (grant[i]) st_d.rsp.grp = w_grp[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < N_WIDE; i++) st_q.wide[i].sz <= SZ_W'(WIDE_MIN);
            st_q.narrow.sz <= SZ_W'(NARROW_MIN);
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid    = st_q.rsp.valid;
    assign rsp_miss     = st_q.rsp.miss;
    assign rsp_win      = st_q.rsp.win;
    assign rsp_grp      = st_q.rsp.grp;
    assign rsp_pci_addr = st_q.rsp.pci;

    // R2: the response appears exactly one edge after the request
    p_rsp_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_miss && rsp_grp == '0 && rsp_pci_addr == '0));

    // R7: a miss drives nothing else
    p_miss_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> (rsp_win == '0 && rsp_grp == '0 && rsp_pci_addr == '0));

    // R3, R4: wide windows never translate
    p_wide_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid ##1 (rsp_valid && !rsp_miss && rsp_win < WIN_W'(N_WIDE)))
        |-> rsp_pci_addr == $past(req_addr));

    // R5: narrow window output stays inside the 32-bit range
    p_narrow_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_miss && rsp_win == WIN_W'(N_WIDE))
        |-> rsp_pci_addr[ADDR_W-1:NARROW_TOP] == '0);
endmodule

// File: tb/mmio_route_decoder_test.sv
module mmio_route_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_idx = '0;
    logic [63:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [47:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_miss;
    logic [4:0]  rsp_win;
    logic [7:0]  rsp_grp;
    logic [47:0] rsp_pci_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mmio_route_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_miss(rsp_miss),
        .rsp_win(rsp_win), .rsp_grp(rsp_grp), .rsp_pci_addr(rsp_pci_addr)
    );

    // behavioural model of the configuration
    bit          m_nen;
    int          m_nsz;
    logic [63:0] m_nbase;
    logic [63:0] m_nremap;
    bit          m_wen  [16];
    bit          m_wseg [16];
    int          m_wsz  [16];
    logic [63:0] m_wbase[16];
    int          m_wgrp [16];
    int          m_tbl  [256];

    bit          e_valid;
    bit          e_miss;
    int          e_win;
    int          e_grp;
    logic [63:0] e_pci;

    function automatic int clampi(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic void model_reset();
        m_nen = 0; m_nsz = 16; m_nbase = 0; m_nremap = 0;
        for (int i = 0; i < 16; i++) begin
            m_wen[i] = 0; m_wseg[i] = 0; m_wsz[i] = 28; m_wbase[i] = 0; m_wgrp[i] = 0;
        end
        for (int i = 0; i < 256; i++) m_tbl[i] = 0;
    endfunction

    function automatic void model_write(input logic [1:0] sel, input logic [7:0] idx, input logic [63:0] wd);
        if (sel == 2'd0) begin
            m_nen    = wd[6];
            m_nsz    = clampi(int'(wd[5:0]), 16, 32);
            m_nbase  = {16'h0, wd[47:16], 16'h0};
            m_nremap = 64'(wd[63:48]);
        end else if (sel == 2'd1) begin
            if (idx < 16) begin
                m_wen[idx]   = wd[6];
                m_wseg[idx]  = wd[7];
                m_wsz[idx]   = clampi(int'(wd[5:0]), 28, 48);
                m_wgrp[idx]  = int'(wd[15:8]);
                m_wbase[idx] = {16'h0, wd[47:16], 16'h0};
            end
        end else if (sel == 2'd2) begin
            m_tbl[idx] = int'(wd[7:0]);
        end
    endfunction

    function automatic void predict(input logic [47:0] a48);
        logic [63:0] a, span, lo;
        a = 64'(a48);
        e_miss = 1; e_win = 0; e_grp = 0; e_pci = 0;
        for (int i = 0; i < 16; i++) begin
            span = 64'd1 << m_wsz[i];
            lo   = (m_wbase[i] / span) * span;
            if (e_miss && m_wen[i] && a >= lo && a < lo + span) begin
                e_miss = 0; e_win = i; e_pci = a;
                e_grp  = m_wseg[i] ? int'(((a - lo) / (span / 256)) % 256) : m_wgrp[i];
            end
        end
        if (e_miss && m_nen) begin
            span = 64'd1 << m_nsz;
            lo   = (m_nbase / span) * span;
            if (a >= lo && a < lo + span) begin
                e_miss = 0; e_win = 16;
                e_grp  = m_tbl[int'((a - lo) / (span / 256))];
                e_pci  = (((m_nremap << 16) / span) * span) % (64'd1 << 32) + (a - lo);
            end
        end
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input bit we, input logic [1:0] sel, input logic [7:0] idx,
                       input logic [63:0] wd, input bit rv, input logic [47:0] ra, input string tag);
        cfg_we = we; cfg_sel = sel; cfg_idx = idx; cfg_wdata = wd;
        req_valid = rv; req_addr = ra;
        e_valid = rv;
        if (rv) predict(ra);
        else begin e_miss = 0; e_win = 0; e_grp = 0; e_pci = 0; end
        @(posedge clk);
        if (we) model_write(sel, idx, wd);
        @(negedge clk);
        chk(tag, "valid", 64'(rsp_valid), 64'(e_valid));
        chk(tag, "miss", 64'(rsp_miss), 64'(e_miss));
        chk(tag, "win", 64'(rsp_win), 64'(e_win));
        chk(tag, "grp", 64'(rsp_grp), 64'(e_grp));
        chk(tag, "pci", 64'(rsp_pci_addr), e_pci);
    endtask

    task automatic look(input logic [47:0] ra, input string tag);
        cyc(0, 2'd3, 8'd0, 64'd0, 1, ra, tag);
    endtask

    function automatic logic [63:0] nword(input bit en, input int sz, input logic [47:0] base, input logic [15:0] remap);
        return {remap, base[47:16], 9'd0, en, 6'(sz)};
    endfunction

    function automatic logic [63:0] wword(input bit en, input bit seg, input int sz, input int grp, input logic [47:0] base);
        return {16'h0, base[47:16], 8'(grp), seg, en, 6'(sz)};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1, R2: idle and reset state
        cyc(0, 2'd3, 0, 0, 0, 48'h0, "R2");
        look(48'h3F_8000_0000, "R1");
        look(48'h00_0000_0000, "R7");
        cyc(0, 2'd3, 0, 0, 0, 48'h0, "R2");

        // R11: table fill, each write also an idle cycle
        for (int k = 0; k < 256; k++)
            cyc(1, 2'd2, 8'(k), 64'((k * 7 + 3) & 255), 0, 48'h0, "R11");

        // R11: write and same-cycle request sees old state
        cyc(1, 2'd0, 0, nword(1, 31, 48'h3F_8000_0000, 16'h8000), 1, 48'h3F_8000_0000, "R11");
        look(48'h3F_8000_0000, "R5");
        look(48'h3F_8080_0004, "R5");
        look(48'h3F_C123_4567, "R5");
        look(48'h3F_7FFF_FFFF, "R7");
        look(48'h40_0000_0000, "R7");
        // R10: top 64 KB of the 32-bit range is still forwarded
        look(48'h3F_FFFF_0010, "R10");
        look(48'h3F_FFFF_FFFF, "R10");

        // R3: unsegmented wide window
        cyc(1, 2'd1, 8'd3, wword(1, 0, 30, 8'h42, 48'h10_0000_0000), 0, 0, "R11");
        look(48'h10_0000_0000, "R3");
        look(48'h10_3FFF_FFF8, "R3");
        look(48'h10_4000_0000, "R7");

        // R4, R8: segmented window with base bits below the size set
        cyc(1, 2'd1, 8'd5, wword(1, 1, 32, 0, 48'h20_0001_0000), 0, 0, "R11");
        look(48'h20_0000_0000, "R4");
        look(48'h20_0100_0000, "R4");
        look(48'h20_FFFF_FFFF, "R8");
        look(48'h20_7A00_1234, "R4");

        // R6: overlap, lower number wins; wide beats narrow
        cyc(1, 2'd1, 8'd2, wword(1, 0, 28, 8'h99, 48'h20_1000_0000), 0, 0, "R11");
        look(48'h20_1000_0040, "R6");
        look(48'h20_2000_0000, "R6");
        cyc(1, 2'd1, 8'd7, wword(1, 0, 28, 8'h77, 48'h3F_9000_0000), 0, 0, "R11");
        look(48'h3F_9000_0100, "R6");
        look(48'h3F_A000_0000, "R6");

        // R11: index above the bank is ignored
        cyc(1, 2'd1, 8'd20, wword(1, 0, 40, 8'h11, 48'h0), 0, 0, "R11");
        look(48'h00_0000_1000, "R11");

        // R9: size clamping
        cyc(1, 2'd1, 8'd9, wword(1, 1, 3, 0, 48'h05_0000_0000), 0, 0, "R11");
        look(48'h05_0FFF_FFFF, "R9");
        look(48'h05_1000_0000, "R9");
        cyc(1, 2'd0, 0, nword(1, 5, 48'h3E_1234_0000, 16'hABCD), 0, 0, "R11");
        look(48'h3E_1234_01FF, "R9");
        look(48'h3E_1235_0000, "R9");

        // mixed traffic around all configured windows
        for (int n = 0; n < 400; n++) begin
            logic [47:0] b;
            logic [47:0] off;
            case (n % 5)
                0: b = 48'h10_0000_0000;
                1: b = 48'h20_0000_0000;
                2: b = 48'h3E_1234_0000;
                3: b = 48'h05_0000_0000;
                default: b = 48'h3F_8000_0000;
            endcase
            off = {$urandom, $urandom} & 48'h0001_FFFF_FFFF;
            if (n % 5 == 2) off = off & 48'h1_FFFF;
            look(b + off, "R6");
        end

        // R9: oversize wide window covers the whole space and beats narrow
        cyc(1, 2'd1, 8'd15, wword(1, 0, 63, 8'h5A, 48'h0), 0, 0, "R11");
        look(48'h3E_1234_0010, "R9");
        look(48'hFF_FFFF_FFFF, "R9");
        look(48'h10_0000_0000, "R6");
        cyc(1, 2'd1, 8'd15, wword(0, 0, 63, 8'h5A, 48'h0), 0, 0, "R11");
        look(48'hFF_FFFF_FFFF, "R7");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule